// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous burst SRAM whose read data flows straight from the registered address to the output pins. It has no output register. It accepts a new read or write on every enabled clock edge, and no idle cycle is needed when the bus turns from writing to reading. Write data is taken one enabled edge after its command and parked in a pending-write register. That register is committed to the array when the next write's data arrives. Any read that targets the parked address sees the parked bytes merged over the array contents.

Commands are loaded or continued by an advance pin. A continued command steps a 2-bit burst counter over the two low address bits, in either linear or interleaved order. Three chip-select pins, a clock enable, a sleep input and an asynchronous output enable control selection, stalling, power-down and bus driving. The bidirectional data bus appears as separate input, output and output-enable signals.

Top module: `ftsram`

## Requirements
- R1: While `rst_n` is low, and after its release until a read command is captured, `dq_oe` is 0.
- R2: A load cycle (`adv`=0) is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other combination is a deselect. A deselect writes nothing, leaves `dq_oe` at 0 in the following cycle, and keeps the block deselected through later `adv`=1 cycles.
- R3: After an enabled edge that captures a selected read load at address A, `dq_out` equals the stored word at A and `dq_oe` is 1 (given `oe_n`=0 and `sleep`=0) during the cycle that follows that edge.
- R4: Write data on `dq_in` is sampled at the enabled edge after the write command's edge. Lane i (bits i*9+8 down to i*9) is updated only if `byte_en_n[i]` was 0 at the command's edge.
- R5: A read issued on the edge right after a write to the same address returns the new bytes for the enabled lanes and the old bytes for the others, with no idle cycle between them.
- R6: `dq_oe` is 0 during the data cycle of every write.
- R7: `oe_n`=1 forces `dq_oe` to 0 at once, with no clock edge needed. Returning `oe_n` to 0 re-enables the output within the same cycle.
- R8: With `mode`=0 (linear), each `adv`=1 cycle of a burst uses low address bits (start + k) mod 4, for k = 1, 2, 3. The upper address bits stay fixed.
- R9: With `mode`=1 (interleaved), each `adv`=1 cycle of a burst uses low address bits start XOR k.
- R10: At an edge where `clk_en`=0, no register changes. The output and the pending write data sample are both delayed to the next enabled edge.
- R11: While `sleep`=1, edges are ignored, nothing is written, and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en | input | 1 | Clock qualifier; 0 stalls every register |
| sleep | input | 1 | Power-down; ignores operations and blanks the output |
| adv | input | 1 | 0 loads a new command, 1 continues the burst |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 writes, 1 reads (sampled on load) |
| byte_en_n | input | LANES | Per-lane write select, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data toward the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
Read data and `dq_oe` are due in the cycle that directly follows the edge that captured the command. Write data is sampled one enabled edge after the write command. A read on the next edge must therefore already reflect that write. The bench drives inputs on the falling edge, advances its own reference model at the rising edge, and samples 1 ns later, which is inside the cycle where each result is due. The `oe_n` case is sampled between edges to show the output reacts without a clock.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
   typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;

   function automatic logic [1:0] burst_step(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input order_e     ord);
      return (ord == ORD_XOR) ? (start ^ cnt) : (start + cnt);
   endfunction
endpackage

// File: rtl/ftsram_cmd.sv
module ftsram_cmd
   import ftsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              adv,
   input  logic              sel,
   input  logic              we_n,
   input  logic              mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  byte_en_n,
   output logic              act_valid,
   output logic              act_wr,
   output logic [ADDR_W-1:0] act_addr,
   output logic [LANES-1:0]  act_mask
);
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q;
   order_e            ord_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_valid <= 1'b0;
         act_wr    <= 1'b0;
         base_q    <= '0;
         cnt_q     <= '0;
         ord_q     <= ORD_LINEAR;
         act_mask  <= '0;
      end else if (step) begin
         act_mask <= ~byte_en_n;
         if (!adv) begin
            act_valid <= sel;
            act_wr    <= ~we_n;
            base_q    <= addr;
            cnt_q     <= 2'd0;
            ord_q     <= order_e'(mode);
         end else if (act_valid) begin
            cnt_q <= cnt_q + 2'd1;
         end
      end
   end

   assign act_addr = {base_q[ADDR_W-1:2], burst_step(base_q[1:0], cnt_q, ord_q)};
endmodule

// File: rtl/ftsram_wbuf.sv
module ftsram_wbuf #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              act_valid,
   input  logic              act_wr,
   input  logic [ADDR_W-1:0] act_addr,
   input  logic [LANES-1:0]  act_mask,
   input  logic [DATA_W-1:0] din,
   output logic              commit,
   output logic              pend_valid,
   output logic [ADDR_W-1:0] pend_addr,
   output logic [LANES-1:0]  pend_mask,
   output logic [DATA_W-1:0] pend_data
);
   logic take;
   assign take   = step & act_valid & act_wr;
   assign commit = take & pend_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_addr  <= '0;
         pend_mask  <= '0;
         pend_data  <= '0;
      end else if (take) begin
         pend_valid <= 1'b1;
         pend_addr  <= act_addr;
         pend_mask  <= act_mask;
         pend_data  <= din;
      end
   end
endmodule

// File: rtl/ftsram_array.sv
module ftsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES-1:0]        wmask,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && wmask[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
   end
endmodule

// File: rtl/ftsram.sv
module ftsram #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en,
   input  logic                    sleep,
   input  logic                    adv,
   input  logic                    cs1_n,
   input  logic                    cs2,
   input  logic                    cs3_n,
   input  logic                    we_n,
   input  logic [LANES-1:0]        byte_en_n,
   input  logic                    mode,
   input  logic                    oe_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   localparam int DATA_W = LANES * LANE_W;

   if (!(LANES == 2 || LANES == 4 || LANES == 8)) begin : g_bad_lanes
      $error("ftsram: LANES must be 2, 4 or 8");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ftsram: ADDR_W must cover the 2-bit burst field");
   end
   if (LANE_W < 2) begin : g_bad_lane_w
      $error("ftsram: LANE_W must hold data plus parity");
   end

   logic              step, sel;
   logic              act_valid, act_wr;
   logic [ADDR_W-1:0] act_addr;
   logic [LANES-1:0]  act_mask;
   logic              commit, pend_valid;
   logic [ADDR_W-1:0] pend_addr;
   logic [LANES-1:0]  pend_mask;
   logic [DATA_W-1:0] pend_data, arr_q;
   logic              hit;

   assign step = clk_en & ~sleep;
   assign sel  = ~cs1_n & cs2 & ~cs3_n;

   ftsram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
      .clk(clk), .rst_n(rst_n), .step(step), .adv(adv), .sel(sel),
      .we_n(we_n), .mode(mode), .addr(addr), .byte_en_n(byte_en_n),
      .act_valid(act_valid), .act_wr(act_wr), .act_addr(act_addr),
      .act_mask(act_mask)
   );

   ftsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .step(step), .act_valid(act_valid),
      .act_wr(act_wr), .act_addr(act_addr), .act_mask(act_mask),
      .din(dq_in), .commit(commit), .pend_valid(pend_valid),
      .pend_addr(pend_addr), .pend_mask(pend_mask), .pend_data(pend_data)
   );

   ftsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .we(commit), .waddr(pend_addr), .wmask(pend_mask),
      .wdata(pend_data), .raddr(act_addr), .rdata(arr_q)
   );

   assign hit = pend_valid && (pend_addr == act_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign dq_out[g*LANE_W +: LANE_W] = (hit && pend_mask[g])
         ? pend_data[g*LANE_W +: LANE_W] : arr_q[g*LANE_W +: LANE_W];
   end

   assign dq_oe = act_valid & ~act_wr & ~oe_n & ~sleep;
endmodule

// File: rtl/ftsram_chk.sv
module ftsram_chk (
   input logic clk,
   input logic rst_n,
   input logic clk_en,
   input logic sleep,
   input logic adv,
   input logic cs1_n,
   input logic cs2,
   input logic cs3_n,
   input logic we_n,
   input logic oe_n,
   input logic dq_oe
);
   logic stp, ld_sel;
   assign stp    = clk_en && !sleep;
   assign ld_sel = !adv && !cs1_n && cs2 && !cs3_n;

   // R7
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_oe);

   // R11
   sleep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);

   // R6
   wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && stp && ld_sel && !we_n) |-> !dq_oe);

   // R3
   rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n && stp && ld_sel && we_n) && !oe_n && !sleep) |-> dq_oe);

   // R2
   desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && stp && !adv && !(!cs1_n && cs2 && !cs3_n)) |-> !dq_oe);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n && !clk_en) && $stable(oe_n) && $stable(sleep)) |-> $stable(dq_oe));
endmodule

bind ftsram ftsram_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep), .adv(adv),
   .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .we_n(we_n), .oe_n(oe_n),
   .dq_oe(dq_oe)
);

// File: tb/ftsram_tb.sv
module ftsram_tb;
   localparam int AW = 6, NL = 4, LW = 9, DW = NL * LW, DEP = 1 << AW;

   logic clk = 0, rst_n = 0, clk_en = 1, sleep = 0, adv = 1;
   logic cs1_n = 0, cs2 = 1, cs3_n = 0, we_n = 1, mode = 0, oe_n = 0;
   logic [NL-1:0] byte_en_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0, dq_out;
   logic dq_oe;

   int errors = 0, checks = 0;
   bit done = 0;

   logic [DW-1:0] ref_mem [DEP];
   logic          m_valid = 0, m_wr = 0, m_il = 0;
   logic [AW-1:0] m_base = '0;
   logic [1:0]    m_cnt = '0;
   logic [NL-1:0] m_mask = '0;

   ftsram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep), .adv(adv),
      .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .we_n(we_n),
      .byte_en_n(byte_en_n), .mode(mode), .oe_n(oe_n), .addr(addr),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always #2.5 clk = ~clk;

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [DW-1:0] s);
      return {a, a, a, a, a, a} ^ s;
   endfunction

   function automatic logic [AW-1:0] m_eff();
      logic [1:0] lo;
      lo = m_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      return {m_base[AW-1:2], lo};
   endfunction

   task automatic chk1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic observe(input string tag);
      logic exp_oe;
      exp_oe = m_valid && !m_wr && !oe_n && !sleep;
      chk1((m_valid && m_wr) ? "R6" : tag, DW'(dq_oe), DW'(exp_oe));
      if (exp_oe) chk1(tag, dq_out, ref_mem[m_eff()]);
   endtask

   // one clock: drive at falling edge, model at rising edge, sample 1 ns later
   task automatic cyc(input logic a, input logic w, input logic [AW-1:0] ad,
                      input logic [NL-1:0] bn, input logic [DW-1:0] d, input string tag);
      @(negedge clk);
      adv = a; we_n = w; addr = ad; byte_en_n = bn; dq_in = d;
      @(posedge clk);
      if (clk_en && !sleep) begin
         if (m_valid && m_wr)
            for (int i = 0; i < NL; i++)
               if (m_mask[i]) ref_mem[m_eff()][i*LW +: LW] = d[i*LW +: LW];
         m_mask = ~bn;
         if (!a) begin
            m_valid = !cs1_n && cs2 && !cs3_n;
            m_wr = !w; m_base = ad; m_cnt = 0; m_il = mode;
         end else if (m_valid) m_cnt = m_cnt + 2'd1;
      end
      #1 observe(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] prev;
      for (int i = 0; i < DEP; i++) ref_mem[i] = '0;
      repeat (3) @(posedge clk);
      #1 chk1("R1", DW'(dq_oe), '0);
      @(negedge clk); rst_n = 1;
      #1 chk1("R1", DW'(dq_oe), '0);

      // R4: back-to-back full writes over every address, then a deselect carries the last data
      prev = '0;
      for (int a = 0; a < DEP; a++) begin
         cyc(0, 0, AW'(a), '0, prev, "R4");
         prev = pat(AW'(a), 36'h5A5A5A5A5);
      end
      cs1_n = 1; cyc(0, 1, 0, '1, prev, "R2"); cs1_n = 0;
      // R3: back-to-back reads of every address
      for (int a = 0; a < DEP; a++) cyc(0, 1, AW'(a), '1, '0, "R3");

      // R4/R5: masked write of each lane pattern, then read of the same address on the next edge
      for (int a = 0; a < 16; a++) begin
         cyc(0, 0, AW'(a), NL'(a), '0, "R4");
         cyc(0, 1, AW'(a), '1, pat(AW'(a), 36'hC3C3C3C3C), "R5");
      end
      for (int a = 0; a < 16; a++) cyc(0, 1, AW'(a), '1, '0, "R4");

      // R2: each chip select wrong in turn: no write, no drive, burst stays off
      for (int k = 0; k < 3; k++) begin
         cs1_n = (k == 0); cs2 = (k != 1); cs3_n = (k == 2);
         cyc(0, 0, 6'd20, '0, '0, "R2");
         cyc(1, 0, 6'd20, '0, '1, "R2");
         cs1_n = 0; cs2 = 1; cs3_n = 0;
         cyc(0, 1, 6'd20, '1, '1, "R2");
      end

      // R8/R9: read bursts from every start offset in both orders
      for (int m = 0; m < 2; m++)
         for (int s = 0; s < 4; s++) begin
            mode = m[0];
            cyc(0, 1, AW'(40 + s), '1, '0, m ? "R9" : "R8");
            for (int k = 1; k < 4; k++) cyc(1, 1, 0, '1, '0, m ? "R9" : "R8");
         end
      // interleaved burst write, then single reads
      mode = 1;
      cyc(0, 0, 6'd50, '0, '0, "R9");
      for (int k = 1; k < 4; k++) cyc(1, 0, 0, '0, pat(AW'(k), 36'h123456789), "R9");
      cyc(0, 1, 6'd48, '1, pat(AW'(4), 36'h123456789), "R9");
      mode = 0;
      for (int a = 48; a < 52; a++) cyc(0, 1, AW'(a), '1, '0, "R9");

      // R7: output enable acts with no clock edge
      oe_n = 1; cyc(0, 1, 6'd7, '1, '0, "R7");
      #1 oe_n = 0; #0.5;
      chk1("R7", DW'(dq_oe), DW'(1)); chk1("R7", dq_out, ref_mem[7]);

      // R10: stall in a read and between a write command and its data
      cyc(0, 1, 6'd9, '1, '0, "R10");
      clk_en = 0;
      cyc(0, 0, 6'd1, '0, '1, "R10");
      cyc(0, 0, 6'd2, '0, '1, "R10");
      clk_en = 1;
      cyc(0, 0, 6'd30, '0, '0, "R10");
      clk_en = 0; cyc(0, 1, 6'd3, '1, '1, "R10"); clk_en = 1;
      cyc(0, 1, 6'd30, '1, 36'h0F0F0F0F0, "R10");

      // R11: sleep ignores a write command and blanks the output
      sleep = 1;
      cyc(0, 0, 6'd31, '0, '0, "R11");
      cyc(1, 0, 6'd31, '0, '1, "R11");
      sleep = 0;
      cyc(0, 1, 6'd31, '1, '0, "R11");
      cyc(0, 1, 6'd30, '1, '0, "R11");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule